// File: doc/BRIEF.md
# Tone-Pair Steering Qualifier

This block sits between a tone-pair detector and the rest of a receiver. On every clock the detector offers a valid flag and a 4-bit code for the tone pair it currently hears. The block turns that raw flag into two steering indications. The first is a fast early-steering flag that follows the qualified detection with one cycle of delay. The second is a delayed-steering flag that rises only after a tone has been present long enough, and falls only after it has been absent long enough. A digital up/down steering counter with two programmable guard counts does the work that a resistor-capacitor network would otherwise do.

When a tone is registered, its code is captured in a 4-bit output latch. The latch is published on a data port that can be switched to high impedance. Here that port is modelled as a value bus plus a separate drive-enable. An inhibit input hides the four extended characters. A power-down input stops all steering activity.

Code map, 4-bit binary: digits 1 to 9 use their own value, digit 0 is 10, star is 11, hash is 12, A, B and C are 13, 14 and 15, and D is 0.

Top module: `tonepair_steer`

## Requirements
- R1: `early_steer` is high one clock edge after the block samples `det_valid`=1 with a code that is not masked and with `pwr_down`=0. It is low one edge after the block samples `det_valid`=0.
- R2: A detection held without a break rises `delayed_steer` at the (`guard_present`+1)th clock edge after the first sampled valid cycle. A detection lasting fewer than `guard_present` cycles registers nothing, and the latch keeps its value.
- R3: When the detection ends, `delayed_steer` falls at the (`guard_absent`+1)th clock edge after `det_valid`=0 is first sampled. While `delayed_steer` is high, a gap in detection shorter than `guard_absent` cycles does not drop it.
- R4: `data_oe` equals `out_en`. When `out_en`=1, `data_q` shows the latched code. When `out_en`=0, `data_q` reads 0 and the port counts as floating.
- R5: With `inhibit`=1, the codes 13, 14, 15 and 0 (A, B, C, D) never raise `early_steer` and are never registered. All other codes behave as usual.
- R6: One edge after `pwr_down`=1 is sampled, `early_steer` and `delayed_steer` are low and the steering counter is cleared. While `pwr_down`=1, nothing is registered. The latched code is kept.
- R7: Reset (`rst_n`=0) clears the latch to 0 and drives both steering flags low.
- R8: A second registration, even of the same code, needs the detection to have been absent for `guard_absent` cycles so that `delayed_steer` is released. A gap of `guard_absent`-1 cycles does not allow it.
- R9: A registration copies the 4-bit code that the detector presented into the latch unchanged, under the code map given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_valid | input | 1 | Detector reports a valid tone pair this cycle |
| det_code | input | 4 | Code of the detected tone pair |
| inhibit | input | 1 | Mask the extended characters A to D |
| pwr_down | input | 1 | Halt all steering activity |
| out_en | input | 1 | Drive the data port; low means high impedance |
| guard_present | input | CNT_W | Presence guard count (steering level needed to register) |
| guard_absent | input | CNT_W | Absence guard count (cycles of silence needed to release) |
| early_steer | output | 1 | Qualified detection, one cycle late |
| delayed_steer | output | 1 | Tone registered and still held |
| data_q | output | 4 | Latched code, 0 while floating |
| data_oe | output | 1 | Drive enable of the data port |

## Verification
A wrong steering counter shows up at the ports as a shifted `delayed_steer` edge. The bench measures the rise and fall latencies to the exact edge, so an off-by-one counter is caught the first time a tone starts or stops. A wrong latch or a wrong masking decision appears as a wrong or unexpected code at the next rising edge of `delayed_steer`, and the scoreboard compares that code on the same cycle. A stuck state after a gap or after power-down appears as a missing re-registration, and the bench reports it before the next tone begins.

// File: rtl/tsl_pkg.sv
package tsl_pkg;

  localparam int CODE_W = 4;
  typedef logic [CODE_W-1:0] code_t;

  // codes of the extended characters
  localparam code_t KEY_A = 4'd13;
  localparam code_t KEY_B = 4'd14;
  localparam code_t KEY_C = 4'd15;
  localparam code_t KEY_D = 4'd0;

  typedef enum logic {ST_FREE, ST_HELD} steer_st_e;

  function automatic logic is_extended(input code_t c);
    return (c == KEY_A) || (c == KEY_B) || (c == KEY_C) || (c == KEY_D);
  endfunction

endpackage

// File: rtl/tsl_early.sv
module tsl_early
  import tsl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  det_valid,
  input  code_t det_code,
  input  logic  inhibit,
  input  logic  pwr_down,
  output logic  early,
  output code_t early_code
);

  logic masked;
  logic qualify;

  assign masked  = inhibit && is_extended(det_code);
  assign qualify = det_valid && !masked && !pwr_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early      <= 1'b0;
      early_code <= '0;
    end else begin
      early <= qualify;
      if (qualify) early_code <= det_code;
    end
  end

endmodule

// File: rtl/tsl_guard.sv
module tsl_guard
  import tsl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             early,
  input  logic [CNT_W-1:0] gp,
  input  logic [CNT_W-1:0] ga,
  output logic             delayed,
  output logic             reg_evt,
  output logic             rel_evt,
  output logic [CNT_W-1:0] level
);

  localparam int CW1 = CNT_W + 1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CW1-1:0]   ONEW = CW1'(1);

  // saturating increment toward a cap
  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] lvl,
                                              input logic [CNT_W-1:0] cap);
    return (lvl >= cap) ? cap : lvl + ONE;
  endfunction

  // saturating decrement toward zero
  function automatic logic [CNT_W-1:0] step_dn(input logic [CNT_W-1:0] lvl);
    return (lvl == '0) ? '0 : lvl - ONE;
  endfunction

  // one more present cycle reaches the presence guard
  function automatic logic hits_present(input logic [CNT_W-1:0] lvl,
                                        input logic [CNT_W-1:0] lim);
    return ({1'b0, lvl} + ONEW) >= {1'b0, lim};
  endfunction

  // one more absent cycle empties the level
  function automatic logic hits_absent(input logic [CNT_W-1:0] lvl);
    return lvl <= ONE;
  endfunction

  steer_st_e        st_q, st_d;
  logic [CNT_W-1:0] lvl_q, lvl_d;

  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    reg_evt = 1'b0;
    rel_evt = 1'b0;
    case (st_q)
      ST_FREE: begin
        if (early) begin
          if (hits_present(lvl_q, gp)) begin
            reg_evt = 1'b1;
            st_d    = ST_HELD;
            lvl_d   = ga;
          end else begin
            lvl_d = step_up(lvl_q, gp);
          end
        end else begin
          lvl_d = step_dn(lvl_q);
        end
      end
      ST_HELD: begin
        if (early) begin
          lvl_d = step_up(lvl_q, ga);
        end else if (hits_absent(lvl_q)) begin
          rel_evt = 1'b1;
          st_d    = ST_FREE;
          lvl_d   = '0;
        end else begin
          lvl_d = step_dn(lvl_q);
        end
      end
      default: begin
        st_d  = ST_FREE;
        lvl_d = '0;
      end
    endcase
    if (pwr_down) begin
      st_d    = ST_FREE;
      lvl_d   = '0;
      reg_evt = 1'b0;
      rel_evt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FREE;
      lvl_q <= '0;
    end else begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
    end
  end

  assign delayed = (st_q == ST_HELD);
  assign level   = lvl_q;

endmodule

// File: rtl/tsl_latch.sv
module tsl_latch
  import tsl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  code_t load_code,
  input  logic  out_en,
  output code_t latch_q,
  output code_t data_q,
  output logic  data_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    latch_q <= '0;
    else if (load) latch_q <= load_code;
  end

  assign data_oe = out_en;
  assign data_q  = out_en ? latch_q : '0;

endmodule

// File: rtl/tonepair_steer.sv
module tonepair_steer
  import tsl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_valid,
  input  logic [3:0]       det_code,
  input  logic             inhibit,
  input  logic             pwr_down,
  input  logic             out_en,
  input  logic [CNT_W-1:0] guard_present,
  input  logic [CNT_W-1:0] guard_absent,
  output logic             early_steer,
  output logic             delayed_steer,
  output logic [3:0]       data_q,
  output logic             data_oe
);

  code_t            early_code;
  code_t            latch_q;
  logic             reg_evt;
  logic             rel_evt;
  logic [CNT_W-1:0] steer_level;

  tsl_early u_early (
    .clk        (clk),
    .rst_n      (rst_n),
    .det_valid  (det_valid),
    .det_code   (det_code),
    .inhibit    (inhibit),
    .pwr_down   (pwr_down),
    .early      (early_steer),
    .early_code (early_code)
  );

  tsl_guard #(.CNT_W(CNT_W)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .early    (early_steer),
    .gp       (guard_present),
    .ga       (guard_absent),
    .delayed  (delayed_steer),
    .reg_evt  (reg_evt),
    .rel_evt  (rel_evt),
    .level    (steer_level)
  );

  tsl_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (reg_evt),
    .load_code (early_code),
    .out_en    (out_en),
    .latch_q   (latch_q),
    .data_q    (data_q),
    .data_oe   (data_oe)
  );

endmodule

// File: rtl/tsl_checker.sv
module tsl_checker
  import tsl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             det_valid,
  input code_t            det_code,
  input logic             inhibit,
  input logic             pwr_down,
  input logic             early,
  input code_t            early_code,
  input logic             delayed,
  input logic             reg_evt,
  input logic             rel_evt,
  input code_t            latch_q,
  input logic [CNT_W-1:0] level
);

  p_early_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (det_valid && !pwr_down && !(inhibit && is_extended(det_code))) |=> early);

  p_early_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !det_valid |=> !early);

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_evt |=> $stable(latch_q));

  p_reg_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_evt |=> (delayed && latch_q == $past(early_code)));

  p_release_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> (!delayed && level == '0));

  p_mask_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && is_extended(det_code)) |=> !early);

  p_pwrdn_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (!early && !delayed && level == '0));

  p_no_reg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_evt |-> !delayed);

endmodule

bind tonepair_steer tsl_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .det_valid  (det_valid),
  .det_code   (det_code),
  .inhibit    (inhibit),
  .pwr_down   (pwr_down),
  .early      (early_steer),
  .early_code (early_code),
  .delayed    (delayed_steer),
  .reg_evt    (reg_evt),
  .rel_evt    (rel_evt),
  .latch_q    (latch_q),
  .level      (steer_level)
);

// File: tb/sim_tonepair_steer.sv
`timescale 1ns/1ps
module sim_tonepair_steer;

  localparam int CNT_W = 8;
  localparam int GP    = 5;
  localparam int GA    = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             det_valid;
  logic [3:0]       det_code;
  logic             inhibit;
  logic             pwr_down;
  logic             out_en;
  logic [CNT_W-1:0] guard_present;
  logic [CNT_W-1:0] guard_absent;
  logic             early_steer;
  logic             delayed_steer;
  logic [3:0]       data_q;
  logic             data_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] exp_q[$];
  bit prev_del = 1'b0;

  always #2 clk = ~clk;

  tonepair_steer #(.CNT_W(CNT_W)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .det_valid     (det_valid),
    .det_code      (det_code),
    .inhibit       (inhibit),
    .pwr_down      (pwr_down),
    .out_en        (out_en),
    .guard_present (guard_present),
    .guard_absent  (guard_absent),
    .early_steer   (early_steer),
    .delayed_steer (delayed_steer),
    .data_q        (data_q),
    .data_oe       (data_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: every rising edge of delayed_steer must match the next expected code
  always @(negedge clk) begin
    if (rst_n) begin
      if (delayed_steer && !prev_del) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected registration", int'(data_q), -1);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(data_q == e, "R9 registered code", int'(data_q), int'(e));
        end
      end
      prev_del = delayed_steer;
    end else begin
      prev_del = 1'b0;
    end
  end

  initial begin
    #800000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    bit flag;
    rst_n = 1'b0; det_valid = 1'b0; det_code = 4'd0; inhibit = 1'b0;
    pwr_down = 1'b0; out_en = 1'b1;
    guard_present = CNT_W'(GP); guard_absent = CNT_W'(GA);
    repeat (3) step();
    // R7 reset state
    chk(early_steer == 1'b0, "R7 early after reset", int'(early_steer), 0);
    chk(delayed_steer == 1'b0, "R7 delayed after reset", int'(delayed_steer), 0);
    chk(data_q == 4'd0, "R7 latch after reset", int'(data_q), 0);
    chk(data_oe == 1'b1, "R4 drive enable", int'(data_oe), 1);
    rst_n = 1'b1;
    repeat (2) step();

    // R1 R2 R3: digit 5, exact latencies
    exp_q.push_back(4'd5);
    det_valid = 1'b1; det_code = 4'd5;
    step();
    chk(early_steer == 1'b1, "R1 early rise", int'(early_steer), 1);
    n = 1;
    while (!delayed_steer && n < 40) begin step(); n++; end
    chk(n == GP + 1, "R2 registration latency", n, GP + 1);
    chk(data_q == 4'd5, "R9 digit 5", int'(data_q), 5);
    repeat (4) step();
    det_valid = 1'b0;
    step();
    chk(early_steer == 1'b0, "R1 early drop", int'(early_steer), 0);
    n = 1;
    while (delayed_steer && n < 40) begin step(); n++; end
    chk(n == GA + 1, "R3 release latency", n, GA + 1);
    repeat (10) step();

    // R2 short tone, one cycle below the presence guard
    flag = 1'b0;
    det_valid = 1'b1; det_code = 4'd9;
    for (int i = 0; i < GP - 1; i++) begin step(); if (delayed_steer) flag = 1'b1; end
    det_valid = 1'b0;
    for (int i = 0; i < 15; i++) begin step(); if (delayed_steer) flag = 1'b1; end
    chk(!flag, "R2 short tone ignored", int'(flag), 0);
    chk(data_q == 4'd5, "R2 latch kept", int'(data_q), 5);

    // R3 R8: gap of GA-1 keeps hold, gap of GA allows a repeat
    exp_q.push_back(4'd3);
    det_valid = 1'b1; det_code = 4'd3;
    repeat (12) step();
    chk(delayed_steer == 1'b1, "R3 held", int'(delayed_steer), 1);
    flag = 1'b1;
    det_valid = 1'b0;
    for (int i = 0; i < GA - 1; i++) begin step(); if (!delayed_steer) flag = 1'b0; end
    det_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin step(); if (!delayed_steer) flag = 1'b0; end
    chk(flag, "R3 short gap keeps hold", int'(flag), 1);
    chk(exp_q.size() == 0, "R8 no repeat after short gap", exp_q.size(), 0);
    exp_q.push_back(4'd3);
    det_valid = 1'b0;
    repeat (GA) step();
    det_valid = 1'b1;
    repeat (GP + 4) step();
    chk(delayed_steer == 1'b1 && data_q == 4'd3, "R8 repeat after full gap",
        int'(delayed_steer), 1);
    chk(exp_q.size() == 0, "R8 repeat registered", exp_q.size(), 0);
    det_valid = 1'b0;
    repeat (12) step();

    // R5 inhibit masks A and D, passes 7
    inhibit = 1'b1;
    det_valid = 1'b1; det_code = 4'd13;
    step();
    chk(early_steer == 1'b0, "R5 A masked", int'(early_steer), 0);
    repeat (GP + 4) step();
    chk(delayed_steer == 1'b0, "R5 A not registered", int'(delayed_steer), 0);
    det_code = 4'd0;
    step();
    chk(early_steer == 1'b0, "R5 D masked", int'(early_steer), 0);
    repeat (GP + 4) step();
    det_valid = 1'b0;
    repeat (3) step();
    chk(data_q == 4'd3, "R5 latch unchanged", int'(data_q), 3);
    exp_q.push_back(4'd7);
    det_valid = 1'b1; det_code = 4'd7;
    repeat (GP + 3) step();
    chk(delayed_steer == 1'b1 && data_q == 4'd7, "R5 digit 7 passes", int'(data_q), 7);
    det_valid = 1'b0;
    repeat (12) step();

    // R9 D and hash with inhibit low
    inhibit = 1'b0;
    exp_q.push_back(4'd0);
    det_valid = 1'b1; det_code = 4'd0;
    repeat (GP + 3) step();
    chk(delayed_steer == 1'b1 && data_q == 4'd0, "R9 D code 0", int'(data_q), 0);
    det_valid = 1'b0;
    repeat (12) step();
    exp_q.push_back(4'd12);
    det_valid = 1'b1; det_code = 4'd12;
    repeat (GP + 3) step();
    chk(data_q == 4'd12, "R9 hash code 12", int'(data_q), 12);
    det_valid = 1'b0;
    repeat (12) step();

    // R4 floating data port
    out_en = 1'b0;
    step();
    chk(data_oe == 1'b0, "R4 drive off", int'(data_oe), 0);
    chk(data_q == 4'd0, "R4 floating value", int'(data_q), 0);
    out_en = 1'b1;
    step();
    chk(data_oe == 1'b1 && data_q == 4'd12, "R4 drive back", int'(data_q), 12);

    // R6 power-down during a held tone
    exp_q.push_back(4'd6);
    det_valid = 1'b1; det_code = 4'd6;
    repeat (GP + 3) step();
    chk(delayed_steer == 1'b1, "R6 held before power-down", int'(delayed_steer), 1);
    pwr_down = 1'b1;
    step();
    chk(early_steer == 1'b0 && delayed_steer == 1'b0, "R6 flags cleared",
        int'(delayed_steer), 0);
    repeat (GP + 4) step();
    chk(delayed_steer == 1'b0, "R6 no registration while down", int'(delayed_steer), 0);
    chk(data_q == 4'd6, "R6 latch kept", int'(data_q), 6);
    det_valid = 1'b0;
    step();
    pwr_down = 1'b0;
    repeat (10) step();
    chk(delayed_steer == 1'b0 && data_q == 4'd6, "R6 after wake", int'(data_q), 6);

    chk(exp_q.size() == 0, "R2 all registrations seen", exp_q.size(), 0);
    finish_run();
  end

endmodule